// File: doc/BRIEF.md
# Modulo Post-Modify Address Generator

This block produces memory addresses for a datapath from a small bank of pointer registers. Each access selects one pointer and one post-modify mode. The pointer's current value appears on the address output in the same cycle, combinationally. At the next clock edge the pointer takes its modified value, so the change is seen by the following access to that pointer.

The modes leave the pointer alone, step it up or down by one with plain binary wrap, or step it up or down by one inside a circular buffer `[0, N-1]`. N comes from a modulus register that the access selects separately from the pointer. A single host write port loads any pointer or modulus register.

The pointer count, the modulus count and the address width are parameters. The defaults are two pointers, two moduli and 8-bit addresses, which cover a 256-word memory.

Top module: `modaddr_gen`

## Requirements
- R1: After reset every pointer and every modulus register holds 0, so an access to any pointer presents address 0.
- R2: While `acc_valid` is high, `addr_out` equals the selected pointer's value before any modification in that cycle, and changes in the same cycle as the select.
- R3: Mode code 0 (hold), and the unused codes 5, 6 and 7, leave the pointer unchanged.
- R4: Mode code 1 adds one to the pointer after the access, wrapping from 255 to 0 at 8 bits.
- R5: Mode code 2 subtracts one from the pointer after the access, wrapping from 0 to 255 at 8 bits.
- R6: Mode code 3 with a non-zero modulus N gives 0 when the pointer equals N-1, and otherwise gives the pointer plus one.
- R7: Mode code 4 with a non-zero modulus N gives N-1 when the pointer equals 0, and otherwise gives the pointer minus one.
- R8: When the selected modulus is 0, mode 3 behaves exactly like mode 1 and mode 4 behaves exactly like mode 2.
- R9: `acc_mod_sel` chooses the modulus register for mode 3 and mode 4 independently of the pointer that `acc_ptr_sel` chooses.
- R10: A host write with `host_wr_target`=0 loads pointer `host_wr_idx`, and with `host_wr_target`=1 loads modulus `host_wr_idx`. The new value is in effect from the next cycle.
- R11: A host write to a pointer wins over a post-modify of the same pointer in the same cycle. A post-modify of a different pointer in that cycle still takes effect.
- R12: When `acc_valid` is low, no pointer changes, whatever the value of `acc_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe; enables the post-modify |
| acc_ptr_sel | input | PSEL_W (1) | Pointer chosen for the access |
| acc_mode | input | 3 | Post-modify code (0 hold, 1 inc, 2 dec, 3 inc mod, 4 dec mod) |
| acc_mod_sel | input | MSEL_W (1) | Modulus register used by modes 3 and 4 |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_target | input | 1 | 0 selects a pointer, 1 selects a modulus |
| host_wr_idx | input | HIDX_W (1) | Index of the register to write |
| host_wr_data | input | ADDR_W (8) | Value to load |
| addr_out | output | ADDR_W (8) | Pre-modify address of the selected pointer |

## Verification
The hardest case to reach is the collision: a host load and a post-modify aimed at the same pointer in the same edge. A second hard case is a load of one pointer while the other pointer advances. The bench drives both strobes in one cycle through a single combined-cycle task, then reads the affected pointers back with hold accesses. The wrap edges (N-1 to 0, 0 to N-1, 255 to 0) are reached by preloading pointers right next to the boundary, so that only two or three steps are needed. The modulus-zero fallback is reached in the same way.

// File: rtl/modaddr_pkg.sv
package modaddr_pkg;

   typedef enum logic [2:0] {
      PM_HOLD    = 3'd0,
      PM_INC     = 3'd1,
      PM_DEC     = 3'd2,
      PM_INC_MOD = 3'd3,
      PM_DEC_MOD = 3'd4
   } post_mode_e;

   typedef enum logic {
      HW_PTR = 1'b0,
      HW_MOD = 1'b1
   } host_target_e;

endpackage

// File: rtl/modaddr_bank.sv
// Register bank: host write has priority over an update of the same slot.
module modaddr_bank #(
   parameter int COUNT = 2,
   parameter int W     = 8,
   parameter int IDX_W = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [IDX_W-1:0]          wr_idx,
   input  logic [W-1:0]              wr_data,
   input  logic                      upd_en,
   input  logic [IDX_W-1:0]          upd_idx,
   input  logic [W-1:0]              upd_data,
   output logic [COUNT-1:0][W-1:0]   q
);

   generate
      for (genvar i = 0; i < COUNT; i++) begin : g_slot
         localparam logic [IDX_W-1:0] SLOT = IDX_W'(i);
         logic [W-1:0] slot_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               slot_q <= '0;
            end else if (wr_en && (wr_idx == SLOT)) begin
               slot_q <= wr_data;
            end else if (upd_en && (upd_idx == SLOT)) begin
               slot_q <= upd_data;
            end
         end

         assign q[i] = slot_q;
      end
   endgenerate

endmodule

// File: rtl/modaddr_pick.sv
// Selects one entry of a packed bank; an out-of-range select yields zero.
module modaddr_pick #(
   parameter int COUNT = 2,
   parameter int W     = 8,
   parameter int SEL_W = 1
) (
   input  logic [COUNT-1:0][W-1:0] bank,
   input  logic [SEL_W-1:0]        sel,
   output logic [W-1:0]            value
);

   always_comb begin
      value = '0;
      for (int i = 0; i < COUNT; i++) begin
         if (sel == SEL_W'(i)) begin
            value = bank[i];
         end
      end
   end

endmodule

// File: rtl/modaddr_step.sv
// Next-pointer computation for every post-modify mode.
module modaddr_step
   import modaddr_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] cur,
   input  logic [ADDR_W-1:0] modv,
   input  logic [2:0]        mode,
   output logic [ADDR_W-1:0] nxt
);

   logic [ADDR_W-1:0] plus_one;
   logic [ADDR_W-1:0] minus_one;
   logic [ADDR_W-1:0] top_slot;
   logic              mod_zero;
   post_mode_e        mode_e;

   assign plus_one  = cur + 1'b1;
   assign minus_one = cur - 1'b1;
   assign top_slot  = modv - 1'b1;
   assign mod_zero  = (modv == '0);
   assign mode_e    = post_mode_e'(mode);

   always_comb begin
      case (mode_e)
         PM_INC:     nxt = plus_one;
         PM_DEC:     nxt = minus_one;
         PM_INC_MOD: nxt = (!mod_zero && (cur == top_slot)) ? '0 : plus_one;
         PM_DEC_MOD: nxt = (!mod_zero && (cur == '0)) ? top_slot : minus_one;
         default:    nxt = cur;
      endcase
   end

endmodule

// File: rtl/modaddr_gen.sv
module modaddr_gen
   import modaddr_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int NUM_PTR = 2,
   parameter int NUM_MOD = 2,
   parameter int PSEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1,
   parameter int MSEL_W  = (NUM_MOD > 1) ? $clog2(NUM_MOD) : 1,
   parameter int HIDX_W  = (PSEL_W > MSEL_W) ? PSEL_W : MSEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [PSEL_W-1:0] acc_ptr_sel,
   input  logic [2:0]        acc_mode,
   input  logic [MSEL_W-1:0] acc_mod_sel,
   input  logic              host_wr_en,
   input  logic              host_wr_target,
   input  logic [HIDX_W-1:0] host_wr_idx,
   input  logic [ADDR_W-1:0] host_wr_data,
   output logic [ADDR_W-1:0] addr_out
);

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("modaddr_gen: ADDR_W must be at least 2");
      end
      if (NUM_PTR < 1 || NUM_MOD < 1) begin : g_bad_count
         $error("modaddr_gen: NUM_PTR and NUM_MOD must be at least 1");
      end
      if ((1 << PSEL_W) < NUM_PTR || (1 << MSEL_W) < NUM_MOD) begin : g_bad_sel
         $error("modaddr_gen: select widths too narrow for register counts");
      end
   endgenerate

   logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_q;
   logic [NUM_MOD-1:0][ADDR_W-1:0] mod_q;
   logic [ADDR_W-1:0]              ptr_cur;
   logic [ADDR_W-1:0]              mod_cur;
   logic [ADDR_W-1:0]              ptr_nxt;
   logic                           ptr_wr;
   logic                           mod_wr;

   assign ptr_wr = host_wr_en && (host_target_e'(host_wr_target) == HW_PTR);
   assign mod_wr = host_wr_en && (host_target_e'(host_wr_target) == HW_MOD);

   modaddr_bank #(.COUNT(NUM_PTR), .W(ADDR_W), .IDX_W(HIDX_W)) u_ptr_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ptr_wr),
      .wr_idx   (host_wr_idx),
      .wr_data  (host_wr_data),
      .upd_en   (acc_valid),
      .upd_idx  (HIDX_W'(acc_ptr_sel)),
      .upd_data (ptr_nxt),
      .q        (ptr_q)
   );

   modaddr_bank #(.COUNT(NUM_MOD), .W(ADDR_W), .IDX_W(HIDX_W)) u_mod_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (mod_wr),
      .wr_idx   (host_wr_idx),
      .wr_data  (host_wr_data),
      .upd_en   (1'b0),
      .upd_idx  ({HIDX_W{1'b0}}),
      .upd_data ({ADDR_W{1'b0}}),
      .q        (mod_q)
   );

   modaddr_pick #(.COUNT(NUM_PTR), .W(ADDR_W), .SEL_W(PSEL_W)) u_ptr_pick (
      .bank  (ptr_q),
      .sel   (acc_ptr_sel),
      .value (ptr_cur)
   );

   modaddr_pick #(.COUNT(NUM_MOD), .W(ADDR_W), .SEL_W(MSEL_W)) u_mod_pick (
      .bank  (mod_q),
      .sel   (acc_mod_sel),
      .value (mod_cur)
   );

   modaddr_step #(.ADDR_W(ADDR_W)) u_step (
      .cur  (ptr_cur),
      .modv (mod_cur),
      .mode (acc_mode),
      .nxt  (ptr_nxt)
   );

   assign addr_out = ptr_cur;

endmodule

// File: rtl/modaddr_gen_chk.sv
module modaddr_gen_chk #(
   parameter int ADDR_W  = 8,
   parameter int NUM_PTR = 2,
   parameter int NUM_MOD = 2,
   parameter int PSEL_W  = 1,
   parameter int MSEL_W  = 1,
   parameter int HIDX_W  = 1
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           acc_valid,
   input logic [PSEL_W-1:0]              acc_ptr_sel,
   input logic [2:0]                     acc_mode,
   input logic [MSEL_W-1:0]              acc_mod_sel,
   input logic                           host_wr_en,
   input logic                           host_wr_target,
   input logic [HIDX_W-1:0]              host_wr_idx,
   input logic [ADDR_W-1:0]              host_wr_data,
   input logic [ADDR_W-1:0]              addr_out,
   input logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_q,
   input logic [NUM_MOD-1:0][ADDR_W-1:0] mod_q
);

   logic              same_hit;
   logic              ptr_write;
   logic [ADDR_W-1:0] exp_inc;
   logic [ADDR_W-1:0] exp_dec;
   logic [ADDR_W-1:0] sel_mod;
   logic [ADDR_W-1:0] sel_last;

   assign ptr_write = host_wr_en && !host_wr_target;
   assign same_hit  = ptr_write && (host_wr_idx == HIDX_W'(acc_ptr_sel));
   assign exp_inc   = addr_out + 1'b1;
   assign exp_dec   = addr_out - 1'b1;
   assign sel_mod   = mod_q[acc_mod_sel];
   assign sel_last  = sel_mod - 1'b1;

   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_mode == 3'd0 && !same_hit)
      |=> ptr_q[$past(acc_ptr_sel)] == $past(addr_out));

   // R4
   inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_mode == 3'd1 && !same_hit)
      |=> ptr_q[$past(acc_ptr_sel)] == $past(exp_inc));

   // R5
   dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_mode == 3'd2 && !same_hit)
      |=> ptr_q[$past(acc_ptr_sel)] == $past(exp_dec));

   // R6
   incmod_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_mode == 3'd3 && !same_hit && sel_mod != '0
       && addr_out == sel_last)
      |=> ptr_q[$past(acc_ptr_sel)] == '0);

   // R7
   decmod_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_mode == 3'd4 && !same_hit && sel_mod != '0
       && addr_out == '0)
      |=> ptr_q[$past(acc_ptr_sel)] == $past(sel_last));

   // R11
   host_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_write |=> ptr_q[$past(host_wr_idx)] == $past(host_wr_data));

   // R12
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_valid && !ptr_write) |=> $stable(ptr_q));

endmodule

bind modaddr_gen modaddr_gen_chk #(
   .ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR), .NUM_MOD(NUM_MOD),
   .PSEL_W(PSEL_W), .MSEL_W(MSEL_W), .HIDX_W(HIDX_W)
) u_chk (.*);

// File: tb/modaddr_gen_tb.sv
module modaddr_gen_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_valid = 1'b0;
   logic [0:0] acc_ptr_sel = '0;
   logic [2:0] acc_mode = '0;
   logic [0:0] acc_mod_sel = '0;
   logic       host_wr_en = 1'b0;
   logic       host_wr_target = 1'b0;
   logic [0:0] host_wr_idx = '0;
   logic [7:0] host_wr_data = '0;
   logic [7:0] addr_out;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   modaddr_gen u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .acc_valid      (acc_valid),
      .acc_ptr_sel    (acc_ptr_sel),
      .acc_mode       (acc_mode),
      .acc_mod_sel    (acc_mod_sel),
      .host_wr_en     (host_wr_en),
      .host_wr_target (host_wr_target),
      .host_wr_idx    (host_wr_idx),
      .host_wr_data   (host_wr_data),
      .addr_out       (addr_out)
   );

   task automatic check_val(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: addr_out=%0d expected %0d", req, act, exp);
      end
   endtask

   // One clock cycle with every strobe given explicitly.
   task automatic cyc(input bit v, input bit sel, input logic [2:0] mode, input bit msel,
                      input bit hw, input bit ht, input bit hidx, input logic [7:0] hdata,
                      input bit chk, input logic [7:0] exp, input string req);
      @(negedge clk);
      acc_valid = v; acc_ptr_sel = sel; acc_mode = mode; acc_mod_sel = msel;
      host_wr_en = hw; host_wr_target = ht; host_wr_idx = hidx; host_wr_data = hdata;
      #1;
      if (chk) check_val(req, addr_out, exp);
      @(posedge clk);
   endtask

   task automatic wr_ptr(input bit idx, input logic [7:0] d);
      cyc(0, 0, 3'd0, 0, 1, 0, idx, d, 0, 8'd0, "");
   endtask

   task automatic wr_mod(input bit idx, input logic [7:0] d);
      cyc(0, 0, 3'd0, 0, 1, 1, idx, d, 0, 8'd0, "");
   endtask

   task automatic acc(input bit sel, input logic [2:0] mode, input bit msel,
                      input logic [7:0] exp, input string req);
      cyc(1, sel, mode, msel, 0, 0, 0, 8'd0, 1, exp, req);
   endtask

   task automatic t_reset();
      acc(0, 3'd0, 0, 8'd0, "R1 ptr0 reset");
      acc(1, 3'd0, 0, 8'd0, "R1 ptr1 reset");
      // modulus resets to 0, so mode 3 steps plainly (R1, R8)
      acc(1, 3'd3, 1, 8'd0, "R1 mod-reset step");
      acc(1, 3'd0, 0, 8'd1, "R1 mod1 reset is zero");
   endtask

   task automatic t_inc();
      wr_ptr(0, 8'd254);
      acc(0, 3'd1, 0, 8'd254, "R10 ptr load / R2");
      acc(0, 3'd1, 0, 8'd255, "R4 inc");
      acc(0, 3'd0, 0, 8'd0,   "R4 inc wraps 255->0");
   endtask

   task automatic t_dec();
      wr_ptr(1, 8'd1);
      acc(1, 3'd2, 0, 8'd1,   "R5 dec start");
      acc(1, 3'd2, 0, 8'd0,   "R5 dec");
      acc(1, 3'd0, 0, 8'd255, "R5 dec wraps 0->255");
   endtask

   task automatic t_incmod();
      wr_mod(0, 8'd5);
      wr_ptr(0, 8'd3);
      acc(0, 3'd3, 0, 8'd3, "R6 incmod start");
      acc(0, 3'd3, 0, 8'd4, "R6 incmod step");
      acc(0, 3'd3, 0, 8'd0, "R6 incmod wrap N-1->0");
      acc(0, 3'd0, 0, 8'd1, "R6 incmod after wrap");
   endtask

   task automatic t_decmod();
      wr_ptr(0, 8'd1);
      acc(0, 3'd4, 0, 8'd1, "R7 decmod start");
      acc(0, 3'd4, 0, 8'd0, "R7 decmod step");
      acc(0, 3'd4, 0, 8'd4, "R7 decmod wrap 0->N-1");
      acc(0, 3'd0, 0, 8'd3, "R7 decmod after wrap");
   endtask

   task automatic t_modsel();
      wr_mod(1, 8'd3);
      wr_ptr(1, 8'd2);
      acc(1, 3'd3, 1, 8'd2, "R9 ptr1 with N1");
      acc(1, 3'd0, 0, 8'd0, "R9 N1=3 wraps 2->0");
      wr_ptr(1, 8'd2);
      acc(1, 3'd3, 0, 8'd2, "R9 ptr1 with N0");
      acc(1, 3'd0, 0, 8'd3, "R9 N0=5 gives 2->3");
   endtask

   task automatic t_zero_mod();
      wr_mod(1, 8'd0);
      wr_ptr(0, 8'd255);
      acc(0, 3'd3, 1, 8'd255, "R8 zero-mod inc start");
      acc(0, 3'd4, 1, 8'd0,   "R8 zero-mod inc 255->0");
      acc(0, 3'd0, 1, 8'd255, "R8 zero-mod dec 0->255");
   endtask

   task automatic t_hold_idle();
      wr_ptr(1, 8'd77);
      acc(1, 3'd0, 0, 8'd77, "R3 hold code 0");
      acc(1, 3'd6, 0, 8'd77, "R3 hold code 6");
      acc(1, 3'd7, 0, 8'd77, "R3 hold code 7");
      acc(1, 3'd5, 0, 8'd77, "R3 hold code 5");
      cyc(0, 1, 3'd1, 0, 0, 0, 0, 8'd0, 0, 8'd0, "");
      cyc(0, 1, 3'd2, 0, 0, 0, 0, 8'd0, 0, 8'd0, "");
      acc(1, 3'd0, 0, 8'd77, "R12 idle leaves pointer");
   endtask

   task automatic t_priority();
      wr_ptr(0, 8'd50);
      // access increments ptr0 while host loads ptr0 = 10
      cyc(1, 0, 3'd1, 0, 1, 0, 0, 8'd10, 1, 8'd50, "R11 collide pre-value");
      acc(0, 3'd0, 0, 8'd10, "R11 host wins on same pointer");
      // access increments ptr0 while host loads ptr1 = 20
      cyc(1, 0, 3'd1, 0, 1, 0, 1, 8'd20, 1, 8'd10, "R11 split pre-value");
      acc(0, 3'd0, 0, 8'd11, "R11 other pointer still steps");
      acc(1, 3'd0, 0, 8'd20, "R10 other pointer loaded");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_inc();
      t_dec();
      t_incmod();
      t_decmod();
      t_modsel();
      t_zero_mod();
      t_hold_idle();
      t_priority();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule